// File: doc/BRIEF.md
# Programmable-Phase Expansion Bus Master

This block is a synchronous master for an external expansion bus. It turns one internal read or write request into a strobe-style bus cycle. On that bus a single read/not-write line gives the direction, and an active-low data strobe marks the transfer. Each cycle passes through five phases in a fixed order: address, data setup, data strobe, hold and recovery. The length of each phase is set by its own timing field.

The internal side is a valid/ready request port. It carries a 24-bit address, 16-bit write data and a write flag. It returns 16-bit read data together with a one-cycle completion pulse. The external side has these signals:

- a chip select
- a 24-bit address
- an address latch enable whose width follows the address-phase setting
- the read/not-write line
- the data strobe
- a bidirectional 16-bit data bus
- an active-low wait input that the target device uses to stretch the strobe

The timing fields are zero-based. A field value of n gives n+1 bus clock cycles. The address, setup and hold fields are 2 bits wide. The strobe and recovery fields are 4 bits wide. All five fields are sampled only when a request is accepted.

Top module: `exp_bus_master`

## Requirements
- R1: Out of reset, and whenever no cycle is active (idle and recovery), the bus pins sit at their inactive levels: bus_cs_no=1, bus_ds_no=1, bus_rnw_o=1 and bus_ale_o=0. The data bus is also released to high impedance.
- R2: req_ready_o is 1 only in idle. A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. At that edge the address, write data, write flag and all five timing fields are captured. Changing these inputs later has no effect on the cycle in progress.
- R3: The address phase lasts cfg_addr_i+1 cycles. During it bus_ale_o=1, bus_cs_no=1, bus_ds_no=1 and bus_addr_o carries the request address. bus_cs_no falls in the same cycle that bus_ale_o falls.
- R4: The setup phase lasts cfg_setup_i+1 cycles. During it bus_ale_o=0, bus_cs_no=0 and bus_ds_no=1. On a write, the write data is driven on bus_data_io.
- R5: When bus_wait_ni stays high, the strobe phase lasts cfg_strobe_i+1 cycles with bus_ds_no=0.
- R6: The hold phase lasts cfg_hold_i+1 cycles, with bus_cs_no=0 and bus_ds_no=1. bus_addr_o does not change while bus_cs_no is 0.
- R7: After hold comes a recovery phase of cfg_recov_i+1 cycles at the inactive levels. Only after it does req_ready_o return to 1.
- R8: bus_rnw_o is 0 from the address phase through the hold phase of a write, and 1 throughout a read. The block drives bus_data_io only during a write while bus_cs_no is 0.
- R9: On a read, rsp_rdata_o takes the value on bus_data_io at the last clock edge of the strobe phase. rsp_done_o is 1 for exactly one cycle per access, and that cycle is the first cycle of recovery.
- R10: Each clock edge of the strobe phase that samples bus_wait_ni=0 freezes the strobe count and keeps bus_ds_no=0. The strobe phase therefore lasts cfg_strobe_i+1 cycles plus one cycle for each such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 2 | Address phase length minus one |
| cfg_setup_i | input | 2 | Data setup phase length minus one |
| cfg_strobe_i | input | 4 | Data strobe phase length minus one |
| cfg_hold_i | input | 2 | Hold phase length minus one |
| cfg_recov_i | input | 4 | Recovery phase length minus one |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 24 | Request address |
| req_wdata_i | input | 16 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Captured read data |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_addr_o | output | 24 | Bus address |
| bus_ale_o | output | 1 | Address latch enable |
| bus_rnw_o | output | 1 | Read/not-write, high for read |
| bus_ds_no | output | 1 | Data strobe, active low |
| bus_data_io | inout | 16 | Bidirectional data bus |
| bus_wait_ni | input | 1 | Wait from target, active low |

## Verification
The bench sweeps every combination of the three short fields. Across that sweep the strobe and recovery lengths and the direction vary, and it measures each phase's length at the pins. An off-by-one in the zero-based counting would show up as every phase one cycle long or short. Changing the timing inputs right after acceptance exposes a design that reads live configuration, because its phase lengths would follow the new values.

The target model drives one read value while the strobe is low and its complement after the strobe rises. Capturing one edge late therefore returns the complement. Wait pulses of several lengths, including one against the shortest strobe, catch a design that lets the counter run or drops the strobe while wait is low. Per-cycle checks of levels and of the address catch a chip select asserted during the latch pulse, a released data bus during a write, or a drifting address.

// File: rtl/exp_bus_pkg.sv
package exp_bus_pkg;
  localparam int SHORT_W = 2;
  localparam int LONG_W  = 4;
  localparam int CNT_W   = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;
endpackage

// File: rtl/exp_phase_timer.sv
module exp_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          freeze_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= len_i;
    else if (!freeze_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !freeze_i;

  // R10: a wait cycle must not consume count
  a_r10_freeze_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/exp_bus_seq.sv
module exp_bus_seq
  import exp_bus_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHORT_W-1:0] cfg_addr_i,
  input  logic [SHORT_W-1:0] cfg_setup_i,
  input  logic [LONG_W-1:0]  cfg_strobe_i,
  input  logic [SHORT_W-1:0] cfg_hold_i,
  input  logic [LONG_W-1:0]  cfg_recov_i,
  input  logic               req_valid_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic               req_write_i,
  input  logic               wait_ni,
  output logic               req_ready_o,
  output phase_e             phase_o,
  output logic               adv_o,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      wdata_o,
  output logic               write_o
);
  phase_e             phase_q, phase_d;
  logic [SHORT_W-1:0] setup_q, hold_q;
  logic [LONG_W-1:0]  strobe_q, recov_q;
  logic [CNT_W-1:0]   len_d;
  logic               accept, freeze, expired, adv;

  assign accept = (phase_q == PH_IDLE) && req_valid_i;
  assign freeze = (phase_q == PH_STROBE) && !wait_ni;
  assign adv    = (phase_q != PH_IDLE) && expired;

  always_comb begin
    phase_d = PH_IDLE;
    len_d   = '0;
    unique case (phase_q)
      PH_IDLE:   begin phase_d = PH_ADDR;   len_d = CNT_W'(cfg_addr_i); end
      PH_ADDR:   begin phase_d = PH_SETUP;  len_d = CNT_W'(setup_q);    end
      PH_SETUP:  begin phase_d = PH_STROBE; len_d = CNT_W'(strobe_q);   end
      PH_STROBE: begin phase_d = PH_HOLD;   len_d = CNT_W'(hold_q);     end
      PH_HOLD:   begin phase_d = PH_RECOV;  len_d = CNT_W'(recov_q);    end
      default:   begin phase_d = PH_IDLE;   len_d = '0;                 end
    endcase
  end

  exp_phase_timer #(.CW(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept || adv),
    .len_i     (len_d),
    .freeze_i  (freeze),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      setup_q  <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      recov_q  <= '0;
      addr_o   <= '0;
      wdata_o  <= '0;
      write_o  <= 1'b0;
    end else if (accept) begin
      phase_q  <= PH_ADDR;
      setup_q  <= cfg_setup_i;
      strobe_q <= cfg_strobe_i;
      hold_q   <= cfg_hold_i;
      recov_q  <= cfg_recov_i;
      addr_o   <= req_addr_i;
      wdata_o  <= req_wdata_i;
      write_o  <= req_write_i;
    end else if (adv) begin
      phase_q  <= phase_d;
    end
  end

  assign req_ready_o = (phase_q == PH_IDLE);
  assign phase_o     = phase_q;
  assign adv_o       = adv;

  // R2: request fields stay fixed for the whole access
  a_r2_fields_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && !adv) |=> ($stable(addr_o) && $stable(write_o) && $stable(strobe_q)));
endmodule

// File: rtl/exp_bus_drive.sv
module exp_bus_drive
  import exp_bus_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          write_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          cs_no,
  output logic          ale_o,
  output logic          rnw_o,
  output logic          ds_no,
  output logic [AW-1:0] addr_o,
  output logic          data_oe_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  logic sel, active;

  assign sel    = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
  assign active = sel || (phase_i == PH_ADDR);

  assign ale_o     = (phase_i == PH_ADDR);
  assign cs_no     = !sel;
  assign ds_no     = (phase_i != PH_STROBE);
  assign rnw_o     = !(active && write_i);
  assign addr_o    = addr_i;
  assign data_oe_o = sel && write_i;
  assign data_o    = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (phase_i == PH_STROBE && adv_i && !write_i) rdata_o <= bus_data_i;
      done_o <= (phase_i == PH_HOLD) && adv_i;
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9: completion lands with chip select already released
  a_r9_done_in_recov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && ds_no));
  // R3: never select the target while the latch pulse is high
  a_r3_no_cs_with_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> cs_no);
endmodule

// File: rtl/exp_bus_master.sv
module exp_bus_master
  import exp_bus_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHORT_W-1:0] cfg_addr_i,
  input  logic [SHORT_W-1:0] cfg_setup_i,
  input  logic [LONG_W-1:0]  cfg_strobe_i,
  input  logic [SHORT_W-1:0] cfg_hold_i,
  input  logic [LONG_W-1:0]  cfg_recov_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic               req_write_i,
  output logic               rsp_done_o,
  output logic [DW-1:0]      rsp_rdata_o,
  output logic               bus_cs_no,
  output logic [AW-1:0]      bus_addr_o,
  output logic               bus_ale_o,
  output logic               bus_rnw_o,
  output logic               bus_ds_no,
  inout  wire  [DW-1:0]      bus_data_io,
  input  logic               bus_wait_ni
);
  phase_e        phase;
  logic          adv, write, data_oe;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, data_out;

  exp_bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_setup_i  (cfg_setup_i),
    .cfg_strobe_i (cfg_strobe_i),
    .cfg_hold_i   (cfg_hold_i),
    .cfg_recov_i  (cfg_recov_i),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_write_i  (req_write_i),
    .wait_ni      (bus_wait_ni),
    .req_ready_o  (req_ready_o),
    .phase_o      (phase),
    .adv_o        (adv),
    .addr_o       (addr),
    .wdata_o      (wdata),
    .write_o      (write)
  );

  exp_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .adv_i      (adv),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .write_i    (write),
    .bus_data_i (bus_data_io),
    .cs_no      (bus_cs_no),
    .ale_o      (bus_ale_o),
    .rnw_o      (bus_rnw_o),
    .ds_no      (bus_ds_no),
    .addr_o     (bus_addr_o),
    .data_oe_o  (data_oe),
    .data_o     (data_out),
    .rdata_o    (rsp_rdata_o),
    .done_o     (rsp_done_o)
  );

  assign bus_data_io = data_oe ? data_out : {DW{1'bz}};

  // R3: chip select follows the falling latch pulse directly
  a_r3_cs_on_ale_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ale_o) |-> !bus_cs_no);
  // R2: an accepted request opens the address phase and drops ready
  a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (bus_ale_o && !req_ready_o));
  // R10: wait low during strobe keeps strobe low
  a_r10_wait_stretches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ds_no && !bus_wait_ni) |=> !bus_ds_no);
  // R6: address steady while selected
  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_addr_o));
  // R1: inactive direction level outside active phases
  a_r1_rnw_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_no && !bus_ale_o) |-> (bus_rnw_o && bus_ds_no));
endmodule

// File: tb/sim_exp_bus_master.sv
`timescale 1ns/1ps
module sim_exp_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_a = '0, cfg_s = '0, cfg_h = '0;
  logic [3:0]  cfg_t = '0, cfg_r = '0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, done, cs_n, ale, rnw, ds_n;
  logic [15:0] rdata;
  logic [23:0] baddr;
  wire  [15:0] bdata;
  logic        wait_n = 1'b1;

  int checks = 0, errors = 0;

  // target model: drives read value while strobe low, complement otherwise
  logic [15:0] dev_rd = '0;
  assign bdata = (!cs_n && rnw) ? (ds_n ? ~dev_rd : dev_rd) : 16'hzzzz;

  always #2 clk = ~clk;

  exp_bus_master u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_addr_i(cfg_a), .cfg_setup_i(cfg_s), .cfg_strobe_i(cfg_t),
    .cfg_hold_i(cfg_h), .cfg_recov_i(cfg_r),
    .req_valid_i(valid), .req_ready_o(ready), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_write_i(wr),
    .rsp_done_o(done), .rsp_rdata_o(rdata),
    .bus_cs_no(cs_n), .bus_addr_o(baddr), .bus_ale_o(ale), .bus_rnw_o(rnw),
    .bus_ds_no(ds_n), .bus_data_io(bdata), .bus_wait_ni(wait_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  int ph = 0, n1, n2, n3, n4, n5, done_cnt, wcnt = 0, wait_len = 0;
  bit done_first, txn_end = 0;
  bit bad_lvl, bad_r3, bad_r4, bad_r6, bad_r8, bad_rdy;
  logic [15:0] rd_cap;
  logic [23:0] e_addr;
  logic [15:0] e_wd;
  bit e_wr;

  always @(negedge clk) begin
    if (rst_n) begin
      case (ph)
        0: if (ale) begin ph = 1; n1 = 1; end
        1: if (ale) n1++; else begin ph = 2; n2 = 1; end
        2: if (ds_n) n2++; else begin ph = 3; n3 = 1; end
        3: if (!ds_n) n3++; else begin ph = 4; n4 = 1; end
        4: if (!cs_n) n4++; else begin ph = 5; n5 = 1; done_first = done; rd_cap = rdata; end
        default: if (!ready) n5++; else begin ph = 0; txn_end = 1; end
      endcase
      if (done) done_cnt++;
      if (ph == 0 || ph == 5)
        if (!(cs_n && ds_n && rnw && !ale && bdata === 16'hzzzz)) bad_lvl = 1;
      if (ph != 0 && ready) bad_rdy = 1;
      if (ph == 1) begin
        if (!(cs_n && ds_n && baddr == e_addr && bdata === 16'hzzzz)) bad_r3 = 1;
        if (rnw != !e_wr) bad_r8 = 1;
      end
      if (ph >= 2 && ph <= 4) begin
        if (cs_n || ale || baddr != e_addr) bad_r6 = 1;
        if (rnw != !e_wr) bad_r8 = 1;
        if (e_wr && bdata !== e_wd) bad_r4 = 1;
      end
      if (!ds_n && wcnt < wait_len) begin wait_n <= 1'b0; wcnt++; end
      else wait_n <= 1'b1;
      if (ds_n) wcnt = 0;
    end
  end

  task automatic xfer(input bit w, input logic [23:0] a, input logic [15:0] d,
                      input logic [15:0] rd, input int t1, input int t2, input int t3,
                      input int t4, input int t5, input int wl);
    e_wr = w; e_addr = a; e_wd = d; dev_rd = rd; wait_len = wl;
    done_cnt = 0; bad_lvl = 0; bad_r3 = 0; bad_r4 = 0; bad_r6 = 0; bad_r8 = 0; bad_rdy = 0;
    chk(ready, "R2 ready before request", ready, 1);
    cfg_a = 2'(t1); cfg_s = 2'(t2); cfg_t = 4'(t3); cfg_h = 2'(t4); cfg_r = 4'(t5);
    wr = w; addr = a; wdata = d; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0;
    // R2: later changes to inputs must not affect the access
    cfg_a = ~cfg_a; cfg_s = ~cfg_s; cfg_t = ~cfg_t; cfg_h = ~cfg_h; cfg_r = ~cfg_r;
    addr = ~addr; wdata = ~wdata; wr = ~wr;
    do begin @(negedge clk); #1; end while (!txn_end);
    txn_end = 0;
    chk(n1 == t1 + 1, "R3 address phase length", n1, t1 + 1);
    chk(n2 == t2 + 1, "R4 setup phase length", n2, t2 + 1);
    if (wl > 0) chk(n3 == t3 + 1 + wl, "R10 stretched strobe length", n3, t3 + 1 + wl);
    else        chk(n3 == t3 + 1, "R5 strobe phase length", n3, t3 + 1);
    chk(n4 == t4 + 1, "R6 hold phase length", n4, t4 + 1);
    chk(n5 == t5 + 1, "R7 recovery length", n5, t5 + 1);
    chk(done_cnt == 1 && done_first, "R9 done pulse", done_cnt, 1);
    if (!w) chk(rd_cap == rd, "R9 read data", rd_cap, rd);
    chk(!bad_r3, "R3 address phase levels", bad_r3, 0);
    chk(!bad_r4, "R4 write data driven", bad_r4, 0);
    chk(!bad_r6, "R6 select and address stable", bad_r6, 0);
    chk(!bad_r8, "R8 direction line", bad_r8, 0);
    chk(!bad_lvl, "R1 inactive levels", bad_lvl, 0);
    chk(!bad_rdy, "R2 ready low while busy", bad_rdy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && ds_n && rnw && !ale && bdata === 16'hzzzz, "R1 levels in reset",
        {cs_n, ds_n, rnw, ale}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ready && !done, "R1 idle after reset", {ready, done}, 2'b10);
    chk(cs_n && ds_n && rnw && !ale && bdata === 16'hzzzz, "R1 idle levels",
        {cs_n, ds_n, rnw, ale}, 4'b1110);
    for (int i = 0; i < 64; i++) begin
      xfer(bit'(i[0] ^ i[3]), 24'h5A0000 + 24'(i * 24'h1357), 16'hC000 + 16'(i * 16'h0119),
           16'h3C00 + 16'(i * 16'h0203),
           i & 3, (i >> 2) & 3, (i * 5) & 15, (i >> 4) & 3, (i * 11) & 15,
           (i % 7 == 0) ? (i % 5) : 0);
    end
    xfer(1'b0, 24'hFFFFFF, 16'h0000, 16'hA55A, 3, 3, 15, 3, 15, 0);
    xfer(1'b1, 24'h000000, 16'hFFFF, 16'h0000, 0, 0, 0, 0, 0, 0);
    xfer(1'b0, 24'h123456, 16'h0, 16'h8001, 0, 0, 0, 0, 0, 3);
    xfer(1'b1, 24'h654321, 16'h7E7E, 16'h0, 1, 2, 2, 1, 3, 5);
    xfer(1'b0, 24'hABCDEF, 16'h0, 16'h1248, 2, 1, 15, 2, 1, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule